// File: doc/BRIEF.md
# HDLC transmit bit framer

This block converts a stream of packet bytes into a serial HDLC bit stream. Bytes arrive on a valid/ready interface that also carries a last-byte marker. Each packet goes out as an opening flag, then the payload bytes least significant bit first, then an optional two-byte CRC-16 frame check sequence, then a closing flag. A zero is inserted after every five consecutive ones in the packet body, so the body can never imitate a flag.

Between packets the line carries either back-to-back flags or continuous ones, chosen by a mode input. An abort input ends the current packet with a run of eight ones. If the byte source runs dry in the middle of a packet, the block aborts the packet by itself and raises a one-cycle underrun pulse. After a closing flag the block can also send a go-ahead pattern: one zero followed by seven ones.

A bit-enable input picks the clock cycles that carry a bit, so the block can serve a slow line or one channel of a time-shared link. In cycles without a bit, nothing moves.

Top module: `hdlc_tx_framer`

## Requirements
- R1: While `rst` is high, and after it falls, `ser_out` is 1 and `in_ready` and `underrun` are 0.
- R2: `ser_out` and all internal progress change only on clock edges where `bit_en` is 1. The bit sequence on the line is the same whatever the spacing of the enabled cycles.
- R3: With no packet pending, the line carries continuous ones when `idle_ones` is 1. When `idle_ones` is 0 it carries back-to-back flags 01111110. Fill is sent in 8-bit units, and a packet starts only when a fill unit ends.
- R4: A packet is sent as the flag 0x7E, then every payload byte least significant bit first, then a closing flag 0x7E.
- R5: In the body (payload and check sequence), a 0 follows every run of five consecutive ones. This includes a run that ends the body, where the 0 comes before the closing flag. Flags, aborts and go-ahead patterns are never stuffed.
- R6: When `crc_en` is 1, two check bytes follow the payload. The CRC uses the reflected polynomial constant 0x8408, starts from 0xFFFF and is sent inverted, low byte first. For the ASCII payload "123456789" the check bytes are 0x6E then 0x90.
- R7: If `in_abort` is 1 on an enabled cycle during a packet, that bit and the next seven bits are ones. Fill then follows, and no closing flag is sent.
- R8: If `in_valid` is 0 when a byte is needed (at the end of the opening flag, or at the end of a byte not marked last), `underrun` pulses for exactly one cycle. Eight ones follow, then fill.
- R9: If `ga_req` is 1 when a closing flag ends, the bits 0 and then seven ones follow before fill.
- R10: A byte is taken on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only on an enabled cycle in which the last bit of the opening flag or of a non-last byte goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | This cycle carries one line bit |
| idle_ones | input | 1 | Fill mode: 1 for ones, 0 for flags |
| crc_en | input | 1 | Append the CRC-16 check sequence |
| ga_req | input | 1 | Send a go-ahead pattern after the closing flag |
| in_valid | input | 1 | Byte available |
| in_data | input | 8 | Payload byte |
| in_last | input | 1 | Byte is the final one of its packet |
| in_abort | input | 1 | Abort the packet in progress |
| in_ready | output | 1 | Byte taken on this edge if valid |
| ser_out | output | 1 | Serial line bit (registered) |
| underrun | output | 1 | One-cycle pulse: packet aborted for lack of data |

## Verification
`ser_out` is registered. It takes a new bit on the clock edge that closes an enabled cycle, so the bench records it on the falling edge after that rising edge, and only for cycles in which `bit_en` was high. The bench reads `in_ready` one time unit after it drives inputs on the falling edge, and counts a byte as taken at the following rising edge. `underrun` is high in the cycle after the enabled edge that found no byte, and the bench reads it on that cycle's falling edge. The expected bit stream, including stuffing and check bytes, is built arithmetically in the bench and matched bit for bit from the first zero on the line. This lines the comparison up with the opening flag regardless of how `bit_en` is spaced.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] PAT_FLAG = 8'h7E;
  localparam logic [BYTE_W-1:0] PAT_ONES = 8'hFF;
  // zero first, then seven ones (LSB leaves first)
  localparam logic [BYTE_W-1:0] PAT_GOAHEAD = 8'hFE;

  typedef enum logic [2:0] {
    ST_FILL, ST_OPEN, ST_BODY, ST_FCS_LO, ST_FCS_HI, ST_CLOSE, ST_GOAHEAD, ST_ABORT
  } tx_state_e;
endpackage

// File: rtl/hdlc_crc16_ser.sv
module hdlc_crc16_ser #(
  parameter logic [15:0] POLY = 16'h8408,
  parameter logic [15:0] INIT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        adv,
  input  logic        din,
  output logic [15:0] crc_q,
  output logic [15:0] crc_d
);
  logic fb;

  always_comb begin
    fb    = crc_q[0] ^ din;
    crc_d = {1'b0, crc_q[15:1]} ^ (fb ? POLY : 16'h0000);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) crc_q <= INIT;
    else if (adv)   crc_q <= crc_d;
  end

  // R6: the remainder only moves on body bits
  assert_crc_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(crc_q));
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int ABORT_LEN = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              idle_ones,
  input  logic              crc_en,
  input  logic              ga_req,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_abort,
  output logic              in_ready,
  output logic              ser_out,
  output logic              underrun,
  output logic              crc_clr,
  output logic              crc_adv,
  output logic              crc_bit,
  input  logic [15:0]       crc_q,
  input  logic [15:0]       crc_d
);
  localparam int CNT_W = $clog2(ABORT_LEN > BYTE_W ? ABORT_LEN : BYTE_W);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  tx_state_e         st;
  logic [BYTE_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic [RUN_W-1:0]  run;
  logic              last_q, ser_q, undr_q, armed;

  logic in_pkt, body_bit, stuff_now, abort_now, advance, unit_end, need_byte, tx_bit;
  logic [BYTE_W-1:0] fill_pat;

  always_comb begin
    in_pkt    = (st == ST_OPEN) || (st == ST_BODY) || (st == ST_FCS_LO) || (st == ST_FCS_HI);
    body_bit  = (st == ST_BODY) || (st == ST_FCS_LO) || (st == ST_FCS_HI);
    abort_now = in_abort && in_pkt;
    stuff_now = (run == RUN_W'(STUFF_RUN)) && (st != ST_ABORT) && !abort_now;
    advance   = bit_en && !stuff_now && !abort_now;
    unit_end  = advance && (cnt == '0);
    need_byte = unit_end && ((st == ST_OPEN) || ((st == ST_BODY) && !last_q));
    fill_pat  = idle_ones ? PAT_ONES : PAT_FLAG;
    if (stuff_now)                            tx_bit = 1'b0;
    else if (abort_now || (st == ST_ABORT))   tx_bit = 1'b1;
    else                                      tx_bit = sh[0];
  end

  assign in_ready = need_byte;
  assign ser_out  = ser_q;
  assign underrun = undr_q;
  assign crc_clr  = (st == ST_OPEN);
  assign crc_adv  = advance && (st == ST_BODY);
  assign crc_bit  = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_FILL;
      sh     <= PAT_ONES;
      cnt    <= CNT_W'(BYTE_W - 1);
      run    <= '0;
      last_q <= 1'b0;
      ser_q  <= 1'b1;
      undr_q <= 1'b0;
      armed  <= 1'b0;
    end else begin
      armed  <= 1'b1;
      undr_q <= 1'b0;
      if (bit_en) begin
        ser_q <= tx_bit;
        if (abort_now) begin
          st  <= ST_ABORT;
          cnt <= CNT_W'(ABORT_LEN - 2);
          run <= '0;
        end else if (stuff_now) begin
          run <= '0;
        end else begin
          run <= (body_bit && sh[0]) ? run + RUN_W'(1) : '0;
          if (cnt != '0) begin
            sh  <= {1'b0, sh[BYTE_W-1:1]};
            cnt <= cnt - CNT_W'(1);
          end else begin
            cnt <= CNT_W'(BYTE_W - 1);
            case (st)
              ST_FILL: begin
                if (in_valid) begin
                  st <= ST_OPEN;
                  sh <= PAT_FLAG;
                end else begin
                  sh <= fill_pat;
                end
              end
              ST_OPEN, ST_BODY: begin
                if ((st == ST_BODY) && last_q) begin
                  st <= crc_en ? ST_FCS_LO : ST_CLOSE;
                  sh <= crc_en ? ~crc_d[7:0] : PAT_FLAG;
                end else if (in_valid) begin
                  st     <= ST_BODY;
                  sh     <= in_data;
                  last_q <= in_last;
                end else begin
                  st     <= ST_ABORT;
                  cnt    <= CNT_W'(ABORT_LEN - 1);
                  undr_q <= 1'b1;
                end
              end
              ST_FCS_LO: begin
                st <= ST_FCS_HI;
                sh <= ~crc_q[15:8];
              end
              ST_FCS_HI: begin
                st <= ST_CLOSE;
                sh <= PAT_FLAG;
              end
              ST_CLOSE: begin
                st <= ga_req ? ST_GOAHEAD : ST_FILL;
                sh <= ga_req ? PAT_GOAHEAD : fill_pat;
              end
              default: begin
                st <= ST_FILL;
                sh <= fill_pat;
              end
            endcase
          end
        end
      end
    end
  end

  // R2: the line is frozen across cycles without a bit
  assert_hold_line_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(bit_en) |-> $stable(ser_q));
  // R5: never more than the stuffing run of body ones is counted
  assert_run_limit_R5: assert property (@(posedge clk) disable iff (rst)
    run <= RUN_W'(STUFF_RUN));
  // R7: every bit of the abort run is a one
  assert_abort_ones_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ABORT && bit_en) |=> ser_q);
  // R8: the underrun flag is a single-cycle pulse
  assert_underrun_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    undr_q |=> !undr_q);
  // R10: bytes are taken only on cycles that carry a bit
  assert_ready_tick_R10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> bit_en);
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer #(
  parameter int          ABORT_LEN = 8,
  parameter int          STUFF_RUN = 5,
  parameter logic [15:0] CRC_POLY  = 16'h8408,
  parameter logic [15:0] CRC_INIT  = 16'hFFFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic       idle_ones,
  input  logic       crc_en,
  input  logic       ga_req,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_last,
  input  logic       in_abort,
  output logic       in_ready,
  output logic       ser_out,
  output logic       underrun
);
  logic        crc_clr, crc_adv, crc_bit;
  logic [15:0] crc_q, crc_d;

  hdlc_crc16_ser #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .adv(crc_adv), .din(crc_bit),
    .crc_q(crc_q), .crc_d(crc_d)
  );

  hdlc_tx_ctrl #(.ABORT_LEN(ABORT_LEN), .STUFF_RUN(STUFF_RUN)) u_ctrl (
    .clk(clk), .rst(rst), .bit_en(bit_en), .idle_ones(idle_ones), .crc_en(crc_en),
    .ga_req(ga_req), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_abort(in_abort), .in_ready(in_ready), .ser_out(ser_out), .underrun(underrun),
    .crc_clr(crc_clr), .crc_adv(crc_adv), .crc_bit(crc_bit), .crc_q(crc_q), .crc_d(crc_d)
  );
endmodule

// File: tb/sim_hdlc_tx_framer.sv
module sim_hdlc_tx_framer;
  logic clk = 1'b0;
  logic rst = 1'b1, bit_en = 1'b0, idle_ones = 1'b1, crc_en = 1'b0, ga_req = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_abort = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, ser_out, underrun;

  hdlc_tx_framer u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .idle_ones(idle_ones), .crc_en(crc_en),
    .ga_req(ga_req), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_abort(in_abort), .in_ready(in_ready), .ser_out(ser_out), .underrun(underrun)
  );

  always #2 clk = ~clk;

  logic rec [0:4095];
  logic expv [0:4095];
  logic [7:0] pkt [0:15];
  int nrec = 0, nexp = 0, checks = 0, errors = 0, done = 0;
  int en_div = 1, cyc = 0, feed_on = 0, nfeed = 0, npkt = 0, pidx = 0, no_last = 0;
  int abort_pend = 0, nundr = 0, hold_viol = 0, ready_viol = 0, run = 0;
  logic be_prev = 1'b0, hs_prev = 1'b0, prev_ser = 1'b1;

  always @(negedge clk) begin
    if (be_prev && nrec < 4096) begin rec[nrec] = ser_out; nrec++; end
    if (!be_prev && !rst && ser_out !== prev_ser) hold_viol++;
    prev_ser = ser_out;
    if (underrun) nundr++;
    if (hs_prev) pidx++;
    cyc++;
    bit_en   = (en_div <= 1) || (cyc % en_div == 0);
    in_valid = (feed_on != 0) && (pidx < nfeed);
    in_data  = (pidx < 16) ? pkt[pidx] : 8'h00;
    in_last  = (pidx == npkt - 1) && (no_last == 0);
    in_abort = (abort_pend != 0);
    #1;
    be_prev = bit_en;
    hs_prev = in_valid && in_ready;
    if (in_ready && !bit_en) ready_viol++;
    if (in_abort && bit_en) abort_pend = 0;
  end

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; feed_on = 0; abort_pend = 0; ga_req = 1'b0; crc_en = 1'b0; idle_ones = 1'b1;
    repeat (3) @(posedge clk);
    #1; rst = 1'b0; nrec = 0; nundr = 0; pidx = 0; hs_prev = 1'b0; nexp = 0; run = 0;
  endtask

  task automatic wait_bits(input int k);
    int t = 0;
    while (nrec < k && t < 30000) begin @(posedge clk); t++; end
  endtask

  task automatic ex_bit(input logic b);
    if (nexp < 4096) begin expv[nexp] = b; nexp++; end
  endtask

  task automatic ex_byte(input logic [7:0] b, input logic stuff);
    for (int i = 0; i < 8; i++) begin
      ex_bit(b[i]);
      if (stuff) begin
        run = b[i] ? run + 1 : 0;
        if (run == 5) begin ex_bit(1'b0); run = 0; end
      end
    end
  endtask

  function automatic logic [15:0] bench_fcs(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        logic fb = c[0] ^ pkt[k][i];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    return ~c;
  endfunction

  function automatic int first_zero(input int from);
    for (int i = from; i < nrec; i++) if (rec[i] == 1'b0) return i;
    return -1;
  endfunction

  task automatic check_stream(input string req);
    int s = first_zero(0);
    int bad = -1;
    checks++;
    if (s < 0 || s + nexp > nrec) begin
      errors++;
      $display("FAIL %s actual=%0d bits expected=%0d bits", req, nrec - s, nexp);
      return;
    end
    for (int i = 0; i < nexp; i++) if (bad < 0 && rec[s+i] !== expv[i]) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s bit %0d actual=%0b expected=%0b", req, bad, rec[s+bad], expv[bad]);
    end
  endtask

  task automatic run_frame(input string req, input int n, input logic crc, input int div,
                           input logic ga, input logic use_fixed, input logic [15:0] fixed_fcs);
    logic [15:0] f;
    do_reset();
    en_div = div; crc_en = crc; ga_req = ga; npkt = n; nfeed = n; no_last = 0;
    ex_byte(8'h7E, 1'b0);
    run = 0;
    for (int k = 0; k < n; k++) ex_byte(pkt[k], 1'b1);
    if (crc) begin
      f = use_fixed ? fixed_fcs : bench_fcs(n);
      ex_byte(f[7:0], 1'b1);
      ex_byte(f[15:8], 1'b1);
    end
    ex_byte(8'h7E, 1'b0);
    if (ga) ex_byte(8'hFE, 1'b0);
    ex_byte(8'hFF, 1'b0);
    feed_on = 1;
    wait_bits(nexp + 24);
    check_stream(req);
  endtask

  initial begin
    #(4 * 190000);
    if (done == 0) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s, j, ok;
    repeat (3) @(posedge clk);
    #1;
    // R1: values while reset is held
    check("R1 ser_out", ser_out, 1);
    check("R1 in_ready", in_ready, 0);
    check("R1 underrun", underrun, 0);

    // R3: continuous ones fill
    do_reset();
    en_div = 1;
    wait_bits(100);
    ok = 1;
    for (int i = 0; i < 100; i++) if (rec[i] !== 1'b1) ok = 0;
    check("R3 ones fill", ok, 1);

    // R3: back-to-back flag fill
    do_reset();
    idle_ones = 1'b0;
    wait_bits(60);
    s = first_zero(0);
    ok = (s >= 0);
    for (int i = 0; i < 32 && ok != 0; i++)
      if (rec[s+i] !== ((i % 8 == 0 || i % 8 == 7) ? 1'b0 : 1'b1)) ok = 0;
    check("R3 flag fill", ok, 1);

    // R4/R5: plain frame with stuffing inside bytes and across byte edges
    pkt[0] = 8'h00; pkt[1] = 8'hFF; pkt[2] = 8'h7E; pkt[3] = 8'h3E;
    run_frame("R4/R5 dense", 4, 1'b0, 1, 1'b0, 1'b0, 16'h0);
    // R2: same frame with one bit every third cycle
    hold_viol = 0; ready_viol = 0;
    run_frame("R2 sparse bit_en", 4, 1'b0, 3, 1'b0, 1'b0, 16'h0);
    check("R2 line held between bits", hold_viol, 0);
    check("R10 ready only on bit cycles", ready_viol, 0);

    // R6: known check vector "123456789"
    for (int k = 0; k < 9; k++) pkt[k] = 8'h31 + 8'(k);
    run_frame("R6 known FCS", 9, 1'b1, 1, 1'b0, 1'b1, 16'h906E);

    // R6/R5: computed FCS over a ones-heavy payload
    pkt[0] = 8'hFF; pkt[1] = 8'hF0; pkt[2] = 8'h1F; pkt[3] = 8'hA5; pkt[4] = 8'hFE;
    run_frame("R6/R5 computed FCS", 5, 1'b1, 2, 1'b0, 1'b0, 16'h0);

    // R5: body ending in five ones gets a zero before the closing flag
    pkt[0] = 8'hF8;
    run_frame("R5 trailing stuff", 1, 1'b0, 1, 1'b0, 1'b0, 16'h0);

    // R9: go-ahead after closing flag
    pkt[0] = 8'h55;
    run_frame("R9 go-ahead", 1, 1'b0, 1, 1'b1, 1'b0, 16'h0);

    // R8: underrun after two bytes of a three-byte packet
    do_reset();
    pkt[0] = 8'h00; pkt[1] = 8'h00; pkt[2] = 8'h00;
    npkt = 3; nfeed = 2; no_last = 1; feed_on = 1;
    wait (pidx >= 1);
    @(posedge clk); #1; idle_ones = 1'b0;
    ex_byte(8'h7E, 1'b0); ex_byte(8'h00, 1'b1); ex_byte(8'h00, 1'b1);
    ex_byte(8'hFF, 1'b0); ex_byte(8'h7E, 1'b0);
    wait_bits(nexp + 24);
    check_stream("R8 underrun stream");
    check("R8 underrun pulses", nundr, 1);

    // R7: abort request in the middle of a zero payload
    do_reset();
    for (int k = 0; k < 6; k++) pkt[k] = 8'h00;
    npkt = 6; nfeed = 6; no_last = 0; feed_on = 1;
    wait (pidx >= 2);
    @(posedge clk); #1;
    idle_ones = 1'b0; feed_on = 0; abort_pend = 1;
    wait_bits(80);
    s = first_zero(0);
    j = -1;
    for (int i = s + 8; i < nrec && j < 0; i++) if (rec[i] == 1'b1) j = i;
    ok = (s >= 0) && (j > 0) && (j + 16 <= nrec);
    for (int i = 0; i < 8 && ok != 0; i++) if (rec[j+i] !== 1'b1) ok = 0;
    for (int i = 0; i < 8 && ok != 0; i++)
      if (rec[j+8+i] !== ((i == 0 || i == 7) ? 1'b0 : 1'b1)) ok = 0;
    check("R7 eight ones then fill", ok, 1);
    check("R7 no underrun on request", nundr, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule